// File: doc/BRIEF.md
# Retirement Stall Watchdog

This block watches the in-order retirement stream of a processor core and raises an error when the oldest instruction fails to retire within a set number of cycles. A counter advances on every cycle in which an instruction is waiting at the head of the retirement queue and nothing retires. It restarts whenever anything retires. When the counter reaches the interval, the block records a machine-check style status word and drives the error outputs.

The output behaviour depends on whether machine-check reporting is live. Reporting is live when the enable input is high and the bank control mask is not all zeros. When it is live, the machine-check error output pulses for three clocks and a one-cycle exception request is raised with vector 0x18. When it is not live, the internal-error output is set and stays high until a reset.

A combined catastrophic-error output follows whichever of the two is active. The logged status word survives a warm reset, so software can read it after the platform restarts. Only a cold reset or an explicit clear strobe empties it.

Top module: `retire_watchdog`

## Requirements
- R1: With the default TIMEOUT of 8 cycles, the timer expires on the clock edge that ends the TIMEOUT-th cycle in which `head_pend_i` is high and `retire_i` is low. The status word and the error outputs change on that edge. One cycle fewer produces no change.
- R2: A cycle with `retire_i` high restarts the count from zero, whether or not `head_pend_i` is high.
- R3: A cycle with `head_pend_i` low and `retire_i` low leaves the count unchanged. Pending cycles on either side of an idle gap therefore add up.
- R4: On expiry with a non-zero `bank_ctl_i` and bit 63 of the status clear, the status becomes: bits [15:0] = 0x0400, bit 38 = 1, bit 61 = 1, bit 63 = 1, and every other bit 0. This value is 64'hA000_0040_0000_0400.
- R5: On expiry with a non-zero `bank_ctl_i` while bit 63 is already set, bit 62 (overflow) is set and all other bits keep their values.
- R6: When `mce_en_i` is 1 and `bank_ctl_i` is non-zero, expiry drives `mcerr_o` high for exactly 3 cycles. It also drives `exc_req_o` high for the first of those cycles, with `exc_vec_o` = 8'h18.
- R7: When `mce_en_i` is 0 or `bank_ctl_i` is zero, expiry sets `ierr_o`, which stays high until a warm or cold reset. `mcerr_o` and `exc_req_o` stay low.
- R8: `caterr_o` is high exactly when `mcerr_o` or `ierr_o` is high. It is a 3-cycle pulse in the reporting case and a held level otherwise.
- R9: With `bank_ctl_i` all zeros, expiry leaves the status word unchanged and raises no machine-check pulse or exception request.
- R10: A warm reset (`rst_warm_n` low for a cycle) clears the timer and all error outputs and keeps the status word.
- R11: A cold reset clears the status word, the timer and the outputs. A `stat_clr_i` cycle sets the status word to zero and takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Synchronous active-low cold reset; clears everything |
| rst_warm_n | input | 1 | Synchronous active-low warm reset; clears timer and outputs only |
| retire_i | input | 1 | An instruction retired this cycle |
| head_pend_i | input | 1 | An instruction is waiting at the head of the retirement queue |
| mce_en_i | input | 1 | Machine-check reporting enabled |
| bank_ctl_i | input | CTL_W | Bank control mask; all zeros means the bank is uninitialized |
| stat_clr_i | input | 1 | Software clear of the status word |
| status_o | output | 64 | Logged status word |
| mcerr_o | output | 1 | Machine-check error pulse |
| ierr_o | output | 1 | Held internal-error level |
| caterr_o | output | 1 | Combined catastrophic-error output |
| exc_req_o | output | 1 | Exception request strobe |
| exc_vec_o | output | 8 | Exception vector that goes with the request |

## Verification
A wrong count in the timer shows up as an expiry one or more cycles early or late. It can also show up as a missing expiry, seen as `status_o` and the error outputs changing on the wrong edge relative to the last pending cycle. A fault in the capture logic shows up at `status_o` on the edge after expiry, as a wrong bit pattern or a missing overflow bit. A fault in the output sequencing shows up within three cycles, as a pulse of the wrong length, a level that drops before reset, or the wrong output chosen for the enable and mask setting. A status word lost on warm reset is visible in the cycle right after that reset.

// File: rtl/rwd_pkg.sv
// Shared constants for the retirement watchdog: status word layout and exception vector.
// Assumes a 64-bit status word; bit positions are fixed because software decodes them.
package rwd_pkg;
    localparam int          STAT_W      = 64;
    localparam int          VALID_BIT   = 63;
    localparam int          OVFL_BIT    = 62;
    localparam int          UNCOR_BIT   = 61;
    localparam int          BUSINIT_BIT = 38;
    localparam logic [15:0] TIMER_CODE  = 16'h0400;
    localparam logic [7:0]  MC_VECTOR   = 8'h18;

    // Builds the status word logged on a first timeout.
    function automatic logic [STAT_W-1:0] first_timeout_word();
        logic [STAT_W-1:0] w;
        w              = '0;
        w[15:0]        = TIMER_CODE;
        w[BUSINIT_BIT] = 1'b1;
        w[UNCOR_BIT]   = 1'b1;
        w[VALID_BIT]   = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/rwd_timer.sv
// Stall timer: counts cycles with an instruction pending at the head and none retiring.
// Assumes TIMEOUT >= 2. expire_o is a one-cycle strobe, gated off while in reset.
module rwd_timer #(
    parameter int TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic retire_i,
    input  logic pend_i,
    output logic expire_o
);
    localparam int          CW   = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    // Expiry when the final counted cycle is another stalled one.
    always_comb expire_o = rst_n && pend_i && !retire_i && (cnt_q == LAST);

    // Counter: restart on retire or expiry, advance on stall, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (retire_i || expire_o) cnt_q <= '0;
        else if (pend_i)               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rwd_status.sv
// Status logger: records the timeout word, flags overflow on a repeat, and clears on request.
// Assumes the word survives warm reset, so only the cold reset is wired here.
module rwd_status
    import rwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_cold_n,
    input  logic              clr_i,
    input  logic              expire_i,
    input  logic              bank_live_i,
    output logic [STAT_W-1:0] status_o
);
    logic [STAT_W-1:0] stat_q;

    // Status register: clear wins, then capture or overflow marking.
    always_ff @(posedge clk) begin
        if (!rst_cold_n)                  stat_q <= '0;
        else if (clr_i)                   stat_q <= '0;
        else if (expire_i && bank_live_i) begin
            if (stat_q[VALID_BIT]) stat_q[OVFL_BIT] <= 1'b1;
            else                   stat_q <= first_timeout_word();
        end
    end

    assign status_o = stat_q;
endmodule

// File: rtl/rwd_pins.sv
// Error output sequencer: a fixed-length pulse plus an exception strobe when reporting is
// live, or a held level otherwise. Assumes rst_n merges the warm and cold resets.
module rwd_pins #(
    parameter int PULSE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic report_i,
    output logic mcerr_o,
    output logic ierr_o,
    output logic exc_req_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;
    logic          ierr_q;
    logic          exc_q;

    // Pulse length counter: loaded on a reported expiry, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    left_q <= '0;
        else if (expire_i && report_i) left_q <= PW'(PULSE_LEN);
        else if (left_q != '0)         left_q <= left_q - 1'b1;
    end

    // Exception strobe: one cycle, aligned with the start of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) exc_q <= 1'b0;
        else        exc_q <= expire_i && report_i;
    end

    // Internal error level: set on an unreported expiry, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ierr_q <= 1'b0;
        else if (expire_i && !report_i) ierr_q <= 1'b1;
    end

    assign mcerr_o   = (left_q != '0);
    assign ierr_o    = ierr_q;
    assign exc_req_o = exc_q;
endmodule

// File: rtl/retire_watchdog.sv
// Retirement watchdog top: ties the stall timer, status logger and output sequencer.
// Assumes synchronous active-low resets; warm reset spares the status word.
module retire_watchdog
    import rwd_pkg::*;
#(
    parameter int TIMEOUT   = 8,
    parameter int CTL_W     = 8,
    parameter int PULSE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_cold_n,
    input  logic              rst_warm_n,
    input  logic              retire_i,
    input  logic              head_pend_i,
    input  logic              mce_en_i,
    input  logic [CTL_W-1:0]  bank_ctl_i,
    input  logic              stat_clr_i,
    output logic [STAT_W-1:0] status_o,
    output logic              mcerr_o,
    output logic              ierr_o,
    output logic              caterr_o,
    output logic              exc_req_o,
    output logic [7:0]        exc_vec_o
);
    logic rst_any_n;
    logic expire;
    logic bank_live;
    logic report;

    // Reset merge and reporting qualification.
    always_comb begin
        rst_any_n = rst_cold_n && rst_warm_n;
        bank_live = |bank_ctl_i;
        report    = mce_en_i && bank_live;
    end

    rwd_timer #(.TIMEOUT(TIMEOUT)) timer_i (
        .clk      (clk),
        .rst_n    (rst_any_n),
        .retire_i (retire_i),
        .pend_i   (head_pend_i),
        .expire_o (expire)
    );

    rwd_status status_i (
        .clk         (clk),
        .rst_cold_n  (rst_cold_n),
        .clr_i       (stat_clr_i),
        .expire_i    (expire),
        .bank_live_i (bank_live),
        .status_o    (status_o)
    );

    rwd_pins #(.PULSE_LEN(PULSE_LEN)) pins_i (
        .clk       (clk),
        .rst_n     (rst_any_n),
        .expire_i  (expire),
        .report_i  (report),
        .mcerr_o   (mcerr_o),
        .ierr_o    (ierr_o),
        .exc_req_o (exc_req_o)
    );

    assign caterr_o  = mcerr_o || ierr_o;
    assign exc_vec_o = MC_VECTOR;
endmodule

// File: rtl/rwd_chk.sv
// Property checker for the retirement watchdog, attached by bind.
// Assumes PULSE_LEN = 3 for the pulse-length property.
module rwd_chk #(
    parameter int CTL_W = 8
) (
    input logic             clk,
    input logic             rst_cold_n,
    input logic             rst_warm_n,
    input logic             mce_en_i,
    input logic [CTL_W-1:0] bank_ctl_i,
    input logic             stat_clr_i,
    input logic [63:0]      status_o,
    input logic             mcerr_o,
    input logic             ierr_o,
    input logic             caterr_o,
    input logic             exc_req_o,
    input logic [7:0]       exc_vec_o
);
    // R6
    mcerr_len_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
        $rose(mcerr_o) |=> mcerr_o ##1 mcerr_o);

    // R6
    exc_vec_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
        exc_req_o |-> (mcerr_o && exc_vec_o == 8'h18));

    // R7
    ierr_hold_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
        ierr_o |=> ierr_o);

    // R8
    caterr_or_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        caterr_o == (mcerr_o || ierr_o));

    // R9
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
        exc_req_o |-> $past(mce_en_i && (|bank_ctl_i)));

    // R4
    code_field_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        status_o[63] |-> (status_o[15:0] == 16'h0400 && status_o[61] && status_o[38]));

    // R11
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (status_o[63] && !stat_clr_i) |=> status_o[63]);
endmodule

bind retire_watchdog rwd_chk #(.CTL_W(CTL_W)) chk_i (
    .clk        (clk),
    .rst_cold_n (rst_cold_n),
    .rst_warm_n (rst_warm_n),
    .mce_en_i   (mce_en_i),
    .bank_ctl_i (bank_ctl_i),
    .stat_clr_i (stat_clr_i),
    .status_o   (status_o),
    .mcerr_o    (mcerr_o),
    .ierr_o     (ierr_o),
    .caterr_o   (caterr_o),
    .exc_req_o  (exc_req_o),
    .exc_vec_o  (exc_vec_o)
);

// File: tb/retire_watchdog_tb.sv
// Directed bench for the retirement watchdog; one task per scenario.
module retire_watchdog_tb_top;
    localparam int T     = 8;
    localparam int CTL_W = 8;
    localparam logic [63:0] FIRST = 64'hA000_0040_0000_0400;
    localparam logic [63:0] OVFL  = 64'hE000_0040_0000_0400;

    logic             clk = 1'b0;
    logic             rst_cold_n = 1'b0;
    logic             rst_warm_n = 1'b1;
    logic             retire_i = 1'b0;
    logic             head_pend_i = 1'b0;
    logic             mce_en_i = 1'b1;
    logic [CTL_W-1:0] bank_ctl_i = 8'h01;
    logic             stat_clr_i = 1'b0;
    logic [63:0]      status_o;
    logic             mcerr_o, ierr_o, caterr_o, exc_req_o;
    logic [7:0]       exc_vec_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    retire_watchdog #(.TIMEOUT(T), .CTL_W(CTL_W), .PULSE_LEN(3)) dut_i (
        .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
        .retire_i(retire_i), .head_pend_i(head_pend_i), .mce_en_i(mce_en_i),
        .bank_ctl_i(bank_ctl_i), .stat_clr_i(stat_clr_i), .status_o(status_o),
        .mcerr_o(mcerr_o), .ierr_o(ierr_o), .caterr_o(caterr_o),
        .exc_req_o(exc_req_o), .exc_vec_o(exc_vec_o)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pins as {mcerr, ierr, caterr, exc_req}.
    function automatic logic [63:0] pins();
        return {60'd0, mcerr_o, ierr_o, caterr_o, exc_req_o};
    endfunction

    task automatic warm_reset();
        rst_warm_n = 1'b0; tick(); rst_warm_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_cold_n = 1'b0; tick(2); rst_cold_n = 1'b1;
        chk("R11 reset status", status_o, 64'd0);
        chk("R11 reset pins", pins(), 64'd0);
    endtask

    task automatic t_retire_restart();
        head_pend_i = 1'b1; tick(T - 1);
        retire_i = 1'b1; tick(); retire_i = 1'b0;
        tick(T - 1);
        chk("R2 no expiry after retire", status_o, 64'd0);
        chk("R2 pins quiet", pins(), 64'd0);
        retire_i = 1'b1; head_pend_i = 1'b0; tick(); retire_i = 1'b0;
    endtask

    task automatic t_hold_and_fire();
        head_pend_i = 1'b1; tick(T - 1);
        head_pend_i = 1'b0; tick(20);
        chk("R3 idle gap no expiry", status_o, 64'd0);
        head_pend_i = 1'b1; tick(); head_pend_i = 1'b0;
        chk("R1 R4 status on expiry", status_o, FIRST);
        chk("R6 R8 pins first cycle", pins(), 64'b1011);
        chk("R6 vector", {56'd0, exc_vec_o}, 64'h18);
        tick();
        chk("R6 pulse cycle 2", pins(), 64'b1010);
        tick();
        chk("R6 pulse cycle 3", pins(), 64'b1010);
        tick();
        chk("R6 R8 pulse ended", pins(), 64'b0000);
    endtask

    task automatic t_overflow_warm();
        head_pend_i = 1'b1; tick(T); head_pend_i = 1'b0;
        chk("R5 overflow bit", status_o, OVFL);
        tick(3);
        warm_reset();
        chk("R10 status kept over warm reset", status_o, OVFL);
        chk("R10 pins cleared", pins(), 64'd0);
    endtask

    task automatic t_clear();
        stat_clr_i = 1'b1; tick(); stat_clr_i = 1'b0;
        chk("R11 software clear", status_o, 64'd0);
    endtask

    task automatic t_disabled();
        mce_en_i = 1'b0;
        head_pend_i = 1'b1; tick(T); head_pend_i = 1'b0;
        chk("R7 R4 status logged when disabled", status_o, FIRST);
        chk("R7 R8 ierr level", pins(), 64'b0110);
        tick(10);
        chk("R7 ierr still held", pins(), 64'b0110);
        warm_reset();
        chk("R7 R10 ierr cleared by warm", pins(), 64'd0);
        chk("R10 status kept", status_o, FIRST);
        rst_cold_n = 1'b0; tick(); rst_cold_n = 1'b1;
        chk("R11 cold reset clears status", status_o, 64'd0);
        mce_en_i = 1'b1;
    endtask

    task automatic t_mask_zero();
        bank_ctl_i = '0;
        head_pend_i = 1'b1; tick(T); head_pend_i = 1'b0;
        chk("R9 status untouched", status_o, 64'd0);
        chk("R9 R7 ierr not mcerr", pins(), 64'b0110);
        tick(3);
        chk("R9 no pulse later", pins(), 64'b0110);
        warm_reset();
        bank_ctl_i = 8'h80;
    endtask

    task automatic t_warm_mid();
        head_pend_i = 1'b1; tick(T - 1);
        warm_reset();
        tick(T - 1);
        chk("R10 warm reset restarted timer", status_o, 64'd0);
        chk("R10 pins quiet", pins(), 64'd0);
        tick(); head_pend_i = 1'b0;
        chk("R1 expiry after restart", status_o, FIRST);
        chk("R1 R6 pins after restart", pins(), 64'b1011);
        tick(3);
    endtask

    initial begin
        t_reset();
        t_retire_restart();
        t_hold_and_fire();
        t_overflow_warm();
        t_clear();
        t_disabled();
        t_mask_zero();
        t_warm_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule